// File: doc/BRIEF.md
# Weight-Resident One-Dimensional Convolution Processing Element

This block computes a one-dimensional, stride-one convolution of a single filter row with a single input feature-map row. It is the basic primitive of a convolution array. First a filter row of S signed 16-bit weights is written into a local weight store, and it stays there for the whole row. Then input activations arrive one at a time into a circular window of depth S. Each new activation overwrites the oldest one, so every activation is fetched exactly once.

For every window position the element runs S multiplies through a two-stage multiply/accumulate pipeline. It then takes one incoming partial sum and adds it to the local dot product. The result is clamped to the signed 16-bit range and presented on the partial-sum output stream. Elements can be chained this way, with the output of one feeding the partial-sum input of the next, so that row results combine into full two-dimensional outputs.

All four data paths are valid/ready streams. Filter length and output count are sampled together with the first filter word. A busy flag covers the span from that word until the last result has been taken.

Top module: `rs_conv_pe`

## Requirements
- R1: After reset, `busy` and `pso_valid` are low, `ifm_ready` and `psi_ready` are low, and `filt_ready` is high.
- R2: A filter word is accepted only while the element is idle or still loading a row. The first accepted word samples `cfg_len` and `cfg_outs` and raises `busy` on the following cycle. A `cfg_len` of 0 acts as 1, a value above 8 acts as 8, and a `cfg_outs` of 0 acts as 1.
- R3: Output k equals clamp(sum over j=0..S-1 of w[j]*x[k+j] + p[k]). Here w[0] is the first weight accepted, x is the activations in arrival order, p[k] is the k-th accepted partial sum, and all values are two's-complement 16-bit numbers.
- R4: For S taps and N outputs, exactly N+S-1 activations are accepted. `ifm_ready` is never high while the element is idle or loading weights.
- R5: Exactly one partial sum is accepted per output, and only after that output's window has been fully multiplied. `psi_ready` and `ifm_ready` are never high together, and an accepted partial sum is followed on the next cycle by `pso_valid`.
- R6: Accumulation is exact for every input combination. The result clamps to 32767 above and to -32768 below, with no wrap-around. Eight taps of -32768 times -32768 give 32767.
- R7: While `pso_valid` is high and `pso_ready` is low, `pso_valid` stays high and `pso_data` stays unchanged. No output is dropped or duplicated.
- R8: `busy` falls on the cycle after the last output is taken, and `filt_ready` returns high at the same time. While an output or partial sum is pending, `filt_ready` is low. A newly loaded row fully replaces the previous weights.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 4 | Filter taps S, sampled with the first filter word |
| cfg_outs | input | 8 | Output count N, sampled with the first filter word |
| busy | output | 1 | High from the first filter word until the last output is taken |
| filt_valid | input | 1 | Filter weight valid |
| filt_ready | output | 1 | Filter weight accepted |
| filt_data | input | 16 | Filter weight, signed |
| ifm_valid | input | 1 | Activation valid |
| ifm_ready | output | 1 | Activation accepted |
| ifm_data | input | 16 | Activation, signed |
| psi_valid | input | 1 | Incoming partial sum valid |
| psi_ready | output | 1 | Incoming partial sum accepted |
| psi_data | input | 16 | Incoming partial sum, signed |
| pso_valid | output | 1 | Result valid |
| pso_ready | input | 1 | Result accepted |
| pso_data | output | 16 | Clamped result, signed |

## Verification
A wrong read pointer into the circular window, or a stale weight, pairs the wrong activation with a tap. This shows up as a wrong value on `pso_data` at the very first output after the window slides, or at the first output after a new row is loaded. An accumulator that is too narrow, or a wrong clamp, shows only on extreme inputs, at the output of that window. Handshake counting errors, such as an extra or missing activation or partial sum, either stall the stream, which ends the run on the time limit, or shift every later result by one position. Back-pressure faults show as a change of `pso_data` while the result is being held.

// File: rtl/rs_pe_pkg.sv
package rs_pe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_FILL  = 3'd2,
        ST_MAC   = 3'd3,
        ST_DRAIN = 3'd4,
        ST_COMB  = 3'd5,
        ST_EMIT  = 3'd6,
        ST_SLIDE = 3'd7
    } pe_state_t;

endpackage

// File: rtl/rs_pe_spad.sv
module rs_pe_spad #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rs_pe_mac.sv
module rs_pe_mac #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic [ACC_W-1:0]  acc,
    output logic              done
);
    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [PROD_W-1:0] prod;
        logic              pv;
        logic              pf;
        logic              pl;
        logic [ACC_W-1:0]  acc;
        logic              done;
    } mac_t;

    mac_t q, d;
    logic signed [PROD_W-1:0] prod_w;
    logic [ACC_W-1:0]         prod_ext;

    assign prod_w   = $signed(in_a) * $signed(in_b);
    assign prod_ext = {{(ACC_W-PROD_W){q.prod[PROD_W-1]}}, q.prod};

    always_comb begin
        d      = q;
        // stage 1: multiply
        d.prod = prod_w;
        d.pv   = in_vld;
        d.pf   = in_first;
        d.pl   = in_last;
        if (in_vld && in_first) begin
            d.done = 1'b0;
        end
        // stage 2: accumulate
        if (q.pv) begin
            d.acc = q.pf ? prod_ext : q.acc + prod_ext;
            if (q.pl) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc  = q.acc;
    assign done = q.done;
endmodule

// File: rtl/rs_conv_pe.sv
module rs_conv_pe
    import rs_pe_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAX_LEN = 8,
    parameter int OUT_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(MAX_LEN+1)-1:0]     cfg_len,
    input  logic [OUT_W-1:0]                 cfg_outs,
    output logic                             busy,
    input  logic                             filt_valid,
    output logic                             filt_ready,
    input  logic [DATA_W-1:0]                filt_data,
    input  logic                             ifm_valid,
    output logic                             ifm_ready,
    input  logic [DATA_W-1:0]                ifm_data,
    input  logic                             psi_valid,
    output logic                             psi_ready,
    input  logic [DATA_W-1:0]                psi_data,
    output logic                             pso_valid,
    input  logic                             pso_ready,
    output logic [DATA_W-1:0]                pso_data
);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int LEN_W = $clog2(MAX_LEN+1);
    localparam int ACC_W = 2 * DATA_W + $clog2(MAX_LEN) + 1;

    typedef struct packed {
        pe_state_t         st;
        logic [LEN_W-1:0]  len;
        logic [OUT_W-1:0]  outs;
        logic [OUT_W-1:0]  ocnt;
        logic [IDX_W-1:0]  wcnt;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tap;
        logic [DATA_W-1:0] res;
    } ctl_t;

    ctl_t q, d;

    logic              w_we, x_we;
    logic [IDX_W-1:0]  w_waddr, x_waddr, x_raddr;
    logic [DATA_W-1:0] w_rdata, x_rdata;
    logic [ACC_W-1:0]  acc;
    logic              acc_done;
    logic              mac_vld, mac_first, mac_last;

    logic [LEN_W-1:0]  len_eff;
    logic [OUT_W-1:0]  outs_eff;
    logic [IDX_W-1:0]  lenm1;
    logic [IDX_W:0]    rsum;
    logic [IDX_W-1:0]  head_nx;
    logic [ACC_W:0]    tot;
    logic [ACC_W-DATA_W+1:0] tot_hi;
    logic [DATA_W-1:0] clamped;

    // configuration clamp
    always_comb begin
        if (cfg_len == '0) begin
            len_eff = LEN_W'(1);
        end else if (cfg_len > LEN_W'(MAX_LEN)) begin
            len_eff = LEN_W'(MAX_LEN);
        end else begin
            len_eff = cfg_len;
        end
        outs_eff = (cfg_outs == '0) ? OUT_W'(1) : cfg_outs;
    end

    // circular window addressing
    always_comb begin
        lenm1 = IDX_W'(q.len - LEN_W'(1));
        rsum  = {1'b0, q.head} + {1'b0, q.tap};
        if (rsum >= (IDX_W+1)'(q.len)) begin
            rsum = rsum - (IDX_W+1)'(q.len);
        end
        x_raddr = rsum[IDX_W-1:0];
        head_nx = (q.head == lenm1) ? '0 : q.head + IDX_W'(1);
    end

    // partial-sum merge and clamp
    always_comb begin
        tot    = {acc[ACC_W-1], acc} + {{(ACC_W+1-DATA_W){psi_data[DATA_W-1]}}, psi_data};
        tot_hi = tot[ACC_W:DATA_W-1];
        if ((&tot_hi) || !(|tot_hi)) begin
            clamped = tot[DATA_W-1:0];
        end else if (tot[ACC_W]) begin
            clamped = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            clamped = {1'b0, {(DATA_W-1){1'b1}}};
        end
    end

    // control
    always_comb begin
        d       = q;
        w_we    = 1'b0;
        w_waddr = q.wcnt;
        x_we    = 1'b0;
        x_waddr = q.wcnt;
        unique case (q.st)
            ST_IDLE: begin
                if (filt_valid) begin
                    w_we    = 1'b1;
                    w_waddr = '0;
                    d.len   = len_eff;
                    d.outs  = outs_eff;
                    d.ocnt  = '0;
                    d.head  = '0;
                    d.tap   = '0;
                    if (len_eff == LEN_W'(1)) begin
                        d.wcnt = '0;
                        d.st   = ST_FILL;
                    end else begin
                        d.wcnt = IDX_W'(1);
                        d.st   = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (filt_valid) begin
                    w_we = 1'b1;
                    if (q.wcnt == lenm1) begin
                        d.wcnt = '0;
                        d.st   = ST_FILL;
                    end else begin
                        d.wcnt = q.wcnt + IDX_W'(1);
                    end
                end
            end
            ST_FILL: begin
                if (ifm_valid) begin
                    x_we = 1'b1;
                    if (q.wcnt == lenm1) begin
                        d.tap = '0;
                        d.st  = ST_MAC;
                    end else begin
                        d.wcnt = q.wcnt + IDX_W'(1);
                    end
                end
            end
            ST_MAC: begin
                if (q.tap == lenm1) begin
                    d.st = ST_DRAIN;
                end else begin
                    d.tap = q.tap + IDX_W'(1);
                end
            end
            ST_DRAIN: begin
                if (acc_done) begin
                    d.st = ST_COMB;
                end
            end
            ST_COMB: begin
                if (psi_valid) begin
                    d.res = clamped;
                    d.st  = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (pso_ready) begin
                    if (q.ocnt == q.outs - OUT_W'(1)) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.ocnt = q.ocnt + OUT_W'(1);
                        d.st   = ST_SLIDE;
                    end
                end
            end
            ST_SLIDE: begin
                if (ifm_valid) begin
                    x_we    = 1'b1;
                    x_waddr = q.head;
                    d.head  = head_nx;
                    d.tap   = '0;
                    d.st    = ST_MAC;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, len: LEN_W'(1), outs: OUT_W'(1), default: '0};
        end else begin
            q <= d;
        end
    end

    assign mac_vld   = (q.st == ST_MAC);
    assign mac_first = (q.tap == '0);
    assign mac_last  = (q.tap == lenm1);

    rs_pe_spad #(.DEPTH(MAX_LEN), .W(DATA_W)) u_wspad (
        .clk(clk), .rst_n(rst_n), .we(w_we), .waddr(w_waddr), .wdata(filt_data),
        .raddr(q.tap), .rdata(w_rdata)
    );

    rs_pe_spad #(.DEPTH(MAX_LEN), .W(DATA_W)) u_xspad (
        .clk(clk), .rst_n(rst_n), .we(x_we), .waddr(x_waddr), .wdata(ifm_data),
        .raddr(x_raddr), .rdata(x_rdata)
    );

    rs_pe_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .in_vld(mac_vld), .in_first(mac_first),
        .in_last(mac_last), .in_a(w_rdata), .in_b(x_rdata), .acc(acc), .done(acc_done)
    );

    assign busy       = (q.st != ST_IDLE);
    assign filt_ready = (q.st == ST_IDLE) || (q.st == ST_LOAD);
    assign ifm_ready  = (q.st == ST_FILL) || (q.st == ST_SLIDE);
    assign psi_ready  = (q.st == ST_COMB);
    assign pso_valid  = (q.st == ST_EMIT);
    assign pso_data   = q.res;
endmodule

// File: rtl/rs_conv_pe_chk.sv
module rs_conv_pe_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              filt_valid,
    input logic              filt_ready,
    input logic              ifm_ready,
    input logic              psi_valid,
    input logic              psi_ready,
    input logic              pso_valid,
    input logic              pso_ready,
    input logic [DATA_W-1:0] pso_data
);
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(filt_valid && filt_ready));

    p_no_ifm_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        filt_ready |-> !ifm_ready);

    p_psi_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(psi_ready && ifm_ready));

    p_psi_to_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (psi_valid && psi_ready) |=> pso_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pso_valid && !pso_ready) |=> (pso_valid && $stable(pso_data)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pso_valid && !psi_ready && !ifm_ready));

    p_no_filt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pso_valid || psi_ready) |-> !filt_ready);
endmodule

bind rs_conv_pe rs_conv_pe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .filt_valid(filt_valid),
    .filt_ready(filt_ready), .ifm_ready(ifm_ready), .psi_valid(psi_valid),
    .psi_ready(psi_ready), .pso_valid(pso_valid), .pso_ready(pso_ready),
    .pso_data(pso_data)
);

// File: tb/sim_rs_conv_pe.sv
module sim_rs_conv_pe;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_len = '0;
    logic [7:0]  cfg_outs = '0;
    logic        busy;
    logic        filt_valid = 1'b0, filt_ready;
    logic [15:0] filt_data = '0;
    logic        ifm_valid = 1'b0, ifm_ready;
    logic [15:0] ifm_data = '0;
    logic        psi_valid = 1'b0, psi_ready;
    logic [15:0] psi_data = '0;
    logic        pso_valid, pso_ready = 1'b0;
    logic [15:0] pso_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int w_arr[8];
    int x_arr[64];
    int p_arr[32];
    int e_arr[32];

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_conv_pe u0 (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_outs(cfg_outs), .busy(busy),
        .filt_valid(filt_valid), .filt_ready(filt_ready), .filt_data(filt_data),
        .ifm_valid(ifm_valid), .ifm_ready(ifm_ready), .ifm_data(ifm_data),
        .psi_valid(psi_valid), .psi_ready(psi_ready), .psi_data(psi_data),
        .pso_valid(pso_valid), .pso_ready(pso_ready), .pso_data(pso_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int s16(input logic [15:0] v);
        return int'($signed(v));
    endfunction

    task automatic push_filt(input int s);
        for (int i = 0; i < s; i++) begin
            @(negedge clk);
            if (($urandom % 3) == 0) begin
                filt_valid = 1'b0;
                @(negedge clk);
            end
            filt_valid = 1'b1;
            filt_data  = 16'(w_arr[i]);
            forever begin
                automatic bit hs = filt_ready;
                @(posedge clk);
                if (hs) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        filt_valid = 1'b0;
    endtask

    task automatic push_ifm(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) begin
                ifm_valid = 1'b0;
                @(negedge clk);
            end
            ifm_valid = 1'b1;
            ifm_data  = 16'(x_arr[i]);
            forever begin
                automatic bit hs = ifm_ready;
                @(posedge clk);
                if (hs) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        ifm_valid = 1'b0;
    endtask

    task automatic push_psi(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) begin
                psi_valid = 1'b0;
                @(negedge clk);
            end
            psi_valid = 1'b1;
            psi_data  = 16'(p_arr[i]);
            forever begin
                automatic bit hs = psi_ready;
                @(posedge clk);
                if (hs) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        psi_valid = 1'b0;
    endtask

    task automatic sink(input int cnt);
        for (int k = 0; k < cnt; k++) begin
            automatic bit held = 1'b0;
            automatic logic [15:0] hv = '0;
            forever begin
                automatic bit rd;
                @(negedge clk);
                if (held) begin
                    chk(pso_valid && (pso_data == hv), "R7 hold", s16(pso_data), s16(hv));
                end
                rd = (($urandom % 4) != 0);
                pso_ready = rd;
                if (pso_valid && rd) begin
                    chk(s16(pso_data) == e_arr[k], "R3/R6 result", s16(pso_data), e_arr[k]);
                    chk(!filt_ready, "R8 filt_ready low while pending", int'(filt_ready), 0);
                    @(posedge clk);
                    break;
                end
                held = pso_valid;
                hv   = pso_data;
            end
        end
        @(negedge clk);
        pso_ready = 1'b0;
        chk(!busy, "R8 busy falls after last output", int'(busy), 0);
        chk(filt_ready, "R8 filt_ready back", int'(filt_ready), 1);
    endtask

    // lc/oc are raw configuration values; arrays must be filled beforehand
    task automatic run_job(input int lc, input int oc);
        automatic int s = (lc == 0) ? 1 : ((lc > 8) ? 8 : lc);
        automatic int n = (oc == 0) ? 1 : oc;
        for (int k = 0; k < n; k++) begin
            automatic longint acc = 0;
            for (int j = 0; j < s; j++) begin
                acc += longint'(w_arr[j]) * longint'(x_arr[k+j]);
            end
            e_arr[k] = clamp16(acc + longint'(p_arr[k]));
        end
        @(negedge clk);
        cfg_len  = 4'(lc);
        cfg_outs = 8'(oc);
        fork
            push_filt(s);
            push_ifm(n + s - 1);
            push_psi(n);
            sink(n);
        join
        // R4: no further activation is taken once the row is done
        ifm_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!ifm_ready, "R4 no extra activation", int'(ifm_ready), 0);
        end
        ifm_valid = 1'b0;
    endtask

    task automatic fill_rand(input int big);
        for (int i = 0; i < 8; i++) w_arr[i] = big ? s16(16'($urandom)) : ($urandom % 41) - 20;
        for (int i = 0; i < 64; i++) x_arr[i] = big ? s16(16'($urandom)) : ($urandom % 201) - 100;
        for (int i = 0; i < 32; i++) p_arr[i] = big ? s16(16'($urandom)) : ($urandom % 2001) - 1000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!pso_valid, "R1 pso_valid", int'(pso_valid), 0);
        chk(!ifm_ready && !psi_ready, "R1 ready low", int'(ifm_ready | psi_ready), 0);
        chk(filt_ready, "R1 filt_ready", int'(filt_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && filt_ready, "R1 idle after reset", int'(busy), 0);

        // directed: single tap (R3)
        fill_rand(0);
        run_job(1, 5);
        // directed: R2 cfg_len 0 acts as 1, cfg_outs 0 acts as 1
        fill_rand(0);
        run_job(0, 0);
        // directed: R2 cfg_len above 8 acts as 8
        fill_rand(0);
        run_job(12, 4);
        // directed: R6 exact accumulation, positive clamp
        for (int i = 0; i < 8; i++) w_arr[i] = -32768;
        for (int i = 0; i < 64; i++) x_arr[i] = -32768;
        for (int i = 0; i < 32; i++) p_arr[i] = 0;
        run_job(8, 3);
        // directed: R6 negative clamp
        for (int i = 0; i < 64; i++) x_arr[i] = 32767;
        run_job(8, 2);
        // directed: R6 edge via partial sum
        w_arr[0] = 1;
        x_arr[0] = 32767; x_arr[1] = 32767; x_arr[2] = -32768; x_arr[3] = -32768;
        p_arr[0] = 1; p_arr[1] = -1; p_arr[2] = -1; p_arr[3] = 1;
        run_job(1, 4);
        // R8: new row replaces weights; R3/R4/R5 random jobs
        for (int t = 0; t < 30; t++) begin
            fill_rand(t % 3 == 0);
            run_job(1 + ($urandom % 8), 1 + ($urandom % 16));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule